// File: doc/BRIEF.md
# Dual-Rate Serial Bit-Clock Generator

This block turns a core clock into the timing pulses a serial transmitter and receiver need. Each direction has two outputs. One is an oversample tick that fires sixteen times per bit. The other is a bit tick that fires once per bit. Every tick is a one-cycle enable that lines up with the core clock, so downstream logic stays in the core clock domain.

Software sets the rates through a small write-only configuration port with three registers. The coarse rate register holds a shared prescale code and one divisor code for each direction. Each direction also has an 8-bit fine register. When a fine register holds a nonzero value, it replaces the coarse setting for its own direction only. Writing zero to a fine register returns that direction to the coarse setting. Rates need not be exact, because asynchronous serial links tolerate a few percent of error. The coarse codes and the fine registers together give settings that stay well inside that margin.

Any write that changes a direction's setting restarts that direction. The next pulses then arrive a full period after the write, and no shortened period is ever produced.

Top module: `baud_gen_dual`

## Requirements
- R1: After reset all registers are zero. Both directions then have an oversample period of one cycle: the oversample tick is high in every cycle, and the bit tick first rises in the 15th cycle after the first clock edge following reset release.
- R2: The write address selects the register: 0 is the coarse rate register, 1 is the receive fine register, 2 is the transmit fine register. Coarse rate register bits [7:6] are the prescale code, where codes 0, 1, 2 and 3 give factors 1, 3, 4 and 13. Bits [5:3] are the receive divisor code n and bits [2:0] are the transmit divisor code n. With its fine register at zero, a direction's oversample period is the prescale factor times 2^n core cycles.
- R3: A nonzero fine value F makes that direction's oversample period exactly F cycles, whatever the coarse setting is.
- R4: The bit tick fires together with every 16th oversample tick of its direction, so the bit period is 16 oversample periods.
- R5: A write to address 0 restarts both directions. A write to address 1 or 2 restarts only the receive or the transmit direction. After a restart with period L, the first oversample tick appears in the L-th cycle after the write edge and the first bit tick in the 16·L-th cycle.
- R6: Writing zero to a fine register makes that direction fall back to its coarse period, starting with a full period from the write.
- R7: The two directions run independently: each direction's period and phase depend only on its own divisor or fine value and its own restarts.
- R8: When the period is longer than one cycle, each tick is high for exactly one core cycle per period.
- R9: A write to address 3 changes no register and restarts nothing.
- R10: When a write arrives in the same cycle as an oversample tick of the direction it restarts, the restart wins. The next tick comes a full new period after the write, and the bit count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe, one write per high cycle |
| cfg_addr | input | 2 | Register address (0 coarse, 1 receive fine, 2 transmit fine) |
| cfg_wdata | input | 8 | Write data |
| rx_os_tick | output | 1 | Receive oversample enable |
| rx_bit_tick | output | 1 | Receive bit-rate enable |
| tx_os_tick | output | 1 | Transmit oversample enable |
| tx_bit_tick | output | 1 | Transmit bit-rate enable |

## Verification
Two things can fall in the same cycle: a configuration write, and the period reload that a tick causes in the direction being written. The bench waits until it sees the receive oversample tick high. It then drives the fine-register write in that same cycle, so both updates meet at one clock edge. The result is judged from the outputs. The next oversample tick must come exactly one new period after the write edge, not one old period later. The bit tick must come after sixteen new periods, which shows the bit count was cleared rather than advanced.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_RX  = 0;
  localparam int unsigned DIR_TX  = 1;

  localparam logic [1:0] CFG_RATE    = 2'd0;
  localparam logic [1:0] CFG_RX_FINE = 2'd1;
  localparam logic [1:0] CFG_TX_FINE = 2'd2;

  // coarse prescale factor selected by the 2-bit code
  function automatic int unsigned prescale_factor(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 3;
      2'd2:    return 4;
      default: return 13;
    endcase
  endfunction

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 3,
  parameter int unsigned FINE_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned RATE_W = 2 + 2 * DIV_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_wr,
  input  logic [1:0]                        cfg_addr,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  output logic [1:0]                        pre_nx,
  output logic [NUM_DIR-1:0][DIV_W-1:0]     div_nx,
  output logic [NUM_DIR-1:0][FINE_W-1:0]    fine_nx,
  output logic [NUM_DIR-1:0]                restart
);

  logic [RATE_W-1:0]              rate_q, rate_d;
  logic [NUM_DIR-1:0][FINE_W-1:0] fine_q, fine_d;

  always_comb begin
    rate_d  = rate_q;
    fine_d  = fine_q;
    restart = '0;
    if (cfg_wr) begin
      case (cfg_addr)
        CFG_RATE: begin
          rate_d  = cfg_wdata[RATE_W-1:0];
          restart = '1;
        end
        CFG_RX_FINE: begin
          fine_d[DIR_RX]  = cfg_wdata[FINE_W-1:0];
          restart[DIR_RX] = 1'b1;
        end
        CFG_TX_FINE: begin
          fine_d[DIR_TX]  = cfg_wdata[FINE_W-1:0];
          restart[DIR_TX] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      fine_q <= '0;
    end else begin
      rate_q <= rate_d;
      fine_q <= fine_d;
    end
  end

  // next-state view lets a restart load the new period in the write cycle
  assign pre_nx         = rate_d[RATE_W-1:2*DIV_W];
  assign div_nx[DIR_RX] = rate_d[2*DIV_W-1:DIV_W];
  assign div_nx[DIR_TX] = rate_d[DIV_W-1:0];
  assign fine_nx        = fine_d;

  AST_SPARE_ADDR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd3) |=> ($stable(rate_q) && $stable(fine_q))); // R9

endmodule

// File: rtl/baud_len_sel.sv
module baud_len_sel
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 3,
  parameter int unsigned FINE_W = 8,
  parameter int unsigned LEN_W  = 11
) (
  input  logic [1:0]        pre_code,
  input  logic [DIV_W-1:0]  div_code,
  input  logic [FINE_W-1:0] fine,
  output logic [LEN_W-1:0]  len
);

  logic [LEN_W-1:0] base;
  logic [LEN_W-1:0] coarse;

  always_comb begin
    base   = LEN_W'(prescale_factor(pre_code));
    coarse = base << div_code;
    len    = (fine != '0) ? LEN_W'(fine) : coarse;
  end

endmodule

// File: rtl/baud_tick_chain.sv
module baud_tick_chain #(
  parameter int unsigned LEN_W    = 11,
  parameter int unsigned OS_RATIO = 16,
  localparam int unsigned BC_W    = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [LEN_W-1:0] len_in,
  output logic             os_tick,
  output logic             bit_tick
);

  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] cnt;
  logic [BC_W-1:0]  bcnt;
  logic             bwrap;

  assign os_tick  = (cnt == '0);
  assign bwrap    = (bcnt == BC_W'(OS_RATIO - 1));
  assign bit_tick = os_tick && bwrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_len <= LEN_W'(1);
      cnt     <= '0;
      bcnt    <= '0;
    end else if (restart) begin
      cur_len <= len_in;
      cnt     <= len_in - LEN_W'(1);
      bcnt    <= '0;
    end else if (os_tick) begin
      cnt  <= cur_len - LEN_W'(1);
      bcnt <= bwrap ? '0 : bcnt + BC_W'(1);
    end else begin
      cnt <= cnt - LEN_W'(1);
    end
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cur_len); // R2

  AST_BIT_ON_OS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick); // R4

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && !restart && cur_len > LEN_W'(1)) |=> !os_tick); // R8

  AST_RESTART_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !bit_tick); // R10

endmodule

// File: rtl/baud_gen_dual.sv
module baud_gen_dual
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W    = 3,
  parameter int unsigned FINE_W   = 8,
  parameter int unsigned OS_RATIO = 16,
  localparam int unsigned RATE_W  = 2 + 2 * DIV_W,
  localparam int unsigned DATA_W  = (RATE_W > FINE_W) ? RATE_W : FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              rx_os_tick,
  output logic              rx_bit_tick,
  output logic              tx_os_tick,
  output logic              tx_bit_tick
);

  // largest coarse period is 13 * 2^(2^DIV_W - 1) < 2^(3 + 2^DIV_W)
  localparam int unsigned COARSE_W = 3 + (1 << DIV_W);
  localparam int unsigned LEN_W    = (COARSE_W > FINE_W) ? COARSE_W : FINE_W;

  logic [1:0]                     pre_nx;
  logic [NUM_DIR-1:0][DIV_W-1:0]  div_nx;
  logic [NUM_DIR-1:0][FINE_W-1:0] fine_nx;
  logic [NUM_DIR-1:0]             restart;
  logic [NUM_DIR-1:0]             os_v;
  logic [NUM_DIR-1:0]             bit_v;

  baud_cfg_regs #(
    .DIV_W  (DIV_W),
    .FINE_W (FINE_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pre_nx    (pre_nx),
    .div_nx    (div_nx),
    .fine_nx   (fine_nx),
    .restart   (restart)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic [LEN_W-1:0] len;

    baud_len_sel #(
      .DIV_W  (DIV_W),
      .FINE_W (FINE_W),
      .LEN_W  (LEN_W)
    ) u_len (
      .pre_code (pre_nx),
      .div_code (div_nx[d]),
      .fine     (fine_nx[d]),
      .len      (len)
    );

    baud_tick_chain #(
      .LEN_W    (LEN_W),
      .OS_RATIO (OS_RATIO)
    ) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart[d]),
      .len_in   (len),
      .os_tick  (os_v[d]),
      .bit_tick (bit_v[d])
    );
  end

  assign rx_os_tick  = os_v[DIR_RX];
  assign rx_bit_tick = bit_v[DIR_RX];
  assign tx_os_tick  = os_v[DIR_TX];
  assign tx_bit_tick = bit_v[DIR_TX];

endmodule

// File: tb/test_baud_gen_dual.sv
module test_baud_gen_dual;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       rx_os_tick, rx_bit_tick, tx_os_tick, tx_bit_tick;

  int vectors = 0;
  int errors  = 0;
  int first_c [4];
  int second_c[4];
  int dbl     [4];

  always #10 clk = ~clk;

  baud_gen_dual i_baud_gen_dual (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .rx_os_tick  (rx_os_tick),
    .rx_bit_tick (rx_bit_tick),
    .tx_os_tick  (tx_os_tick),
    .tx_bit_tick (tx_bit_tick)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_now(input logic [1:0] a, input logic [7:0] d);
    cfg_wr    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(posedge clk);
    #1 cfg_wr = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  // index: 0 rx_os, 1 rx_bit, 2 tx_os, 3 tx_bit; cycle 1 follows the last edge
  task automatic run_window(input int win);
    logic [3:0] prev = 4'b0;
    for (int i = 0; i < 4; i++) begin
      first_c[i] = 0; second_c[i] = 0; dbl[i] = 0;
    end
    for (int k = 1; k <= win; k++) begin
      logic [3:0] v;
      @(negedge clk);
      v = {tx_bit_tick, tx_os_tick, rx_bit_tick, rx_os_tick};
      for (int i = 0; i < 4; i++) begin
        if (v[i]) begin
          if (first_c[i] == 0) first_c[i] = k;
          else if (second_c[i] == 0) second_c[i] = k;
          if (prev[i]) dbl[i]++;
        end
      end
      prev = v;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "rx_bit during reset", rx_bit_tick, 0);
    rst_n = 1'b1;
    run_window(40);
    chk("R1", "rx_os first", first_c[0], 1);
    chk("R1", "rx_os second", second_c[0], 2);
    chk("R1", "rx_bit first", first_c[1], 15);
    chk("R1", "tx_bit first", first_c[3], 15);
    chk("R4", "rx_bit period", second_c[1] - first_c[1], 16);
  endtask

  task automatic t_coarse_a;
    wr(2'd0, {2'b01, 3'd2, 3'd1});          // rx 3*4=12, tx 3*2=6
    run_window(400);
    chk("R2", "rx_os first", first_c[0], 12);
    chk("R2", "rx_os period", second_c[0] - first_c[0], 12);
    chk("R2", "tx_os first", first_c[2], 6);
    chk("R7", "tx_os period", second_c[2] - first_c[2], 6);
    chk("R4", "rx_bit first", first_c[1], 192);
    chk("R4", "tx_bit first", first_c[3], 96);
    chk("R4", "tx_bit period", second_c[3] - first_c[3], 96);
    chk("R8", "rx_os back-to-back", dbl[0], 0);
    chk("R8", "tx_bit back-to-back", dbl[3], 0);
  endtask

  task automatic t_coarse_max;
    wr(2'd0, {2'b11, 3'd7, 3'd0});          // rx 13*128, tx 13
    run_window(26700);
    chk("R2", "rx_os first max", first_c[0], 1664);
    chk("R2", "rx_os period max", second_c[0] - first_c[0], 1664);
    chk("R4", "rx_bit first max", first_c[1], 26624);
    chk("R2", "tx_os first", first_c[2], 13);
  endtask

  task automatic t_coarse_b;
    wr(2'd0, {2'b10, 3'd3, 3'd5});          // rx 4*8=32, tx 4*32=128
    run_window(600);
    chk("R2", "rx_os first", first_c[0], 32);
    chk("R2", "tx_os first", first_c[2], 128);
    chk("R4", "rx_bit first", first_c[1], 512);
  endtask

  task automatic t_fine_rx;
    wr(2'd0, {2'b00, 3'd0, 3'd4});          // rx 1, tx 16
    wr(2'd1, 8'd5);                         // rx fine 5, tx untouched
    run_window(200);
    chk("R3", "rx_os first", first_c[0], 5);
    chk("R3", "rx_os period", second_c[0] - first_c[0], 5);
    chk("R5", "rx_bit first", first_c[1], 80);
    chk("R5", "tx_os not restarted", first_c[2], 15);
    chk("R7", "tx_os period", second_c[2] - first_c[2], 16);
  endtask

  task automatic t_fine_zero;
    wr(2'd0, {2'b01, 3'd1, 3'd0});          // coarse rx 6, tx 3 (rx fine still 5)
    wr(2'd1, 8'd9);
    wr(2'd1, 8'd0);                         // rx back to coarse 6
    run_window(200);
    chk("R6", "rx_os first", first_c[0], 6);
    chk("R6", "rx_os period", second_c[0] - first_c[0], 6);
    chk("R6", "rx_bit first", first_c[1], 96);
    chk("R7", "tx_os phase", first_c[2], 1);
    chk("R7", "tx_os period", second_c[2] - first_c[2], 3);
  endtask

  task automatic t_fine_tx;
    wr(2'd2, 8'd200);
    run_window(450);
    chk("R3", "tx_os first", first_c[2], 200);
    chk("R3", "tx_os period", second_c[2] - first_c[2], 200);
    chk("R7", "rx_os period", second_c[0] - first_c[0], 6);
  endtask

  task automatic t_spare_addr;
    wr(2'd0, {2'b01, 3'd1, 3'd0});          // rx 6 coarse, tx fine 200
    wr(2'd3, 8'hFF);
    run_window(3300);
    chk("R9", "rx_os first", first_c[0], 5);
    chk("R9", "tx_os first", first_c[2], 199);
    chk("R9", "rx_bit first", first_c[1], 95);
    chk("R9", "tx_bit first", first_c[3], 3199);
    chk("R8", "tx_os back-to-back", dbl[2], 0);
  endtask

  task automatic t_collision;
    int guard = 0;
    @(negedge clk);
    while (!rx_os_tick && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk("R10", "tick seen before write", rx_os_tick, 1);
    wr_now(2'd1, 8'd4);                     // write lands with the tick
    run_window(100);
    chk("R10", "rx_os first", first_c[0], 4);
    chk("R10", "rx_os period", second_c[0] - first_c[0], 4);
    chk("R10", "rx_bit first", first_c[1], 64);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_coarse_a();
    t_coarse_max();
    t_coarse_b();
    t_fine_rx();
    t_fine_zero();
    t_fine_tx();
    t_spare_addr();
    t_collision();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule